// File: doc/BRIEF.md
# Pulse Period and Width Capture

This block measures the timing of a slow digital input in units of a selectable count clock. A prescaler divides the system clock by 1, 16, 64 or 512 to make that count clock. A 16-bit up-counter advances once per count tick. When the input shows a measuring edge, the counter value is copied into a capture register, and the counter restarts for the next interval.

Two measuring modes are provided. In period mode only one edge polarity measures, so each capture covers a full cycle of the input. In width mode both polarities measure, so each capture covers one level of the input: a high level or a low level.

Software sees only the capture register and never the running count. An interrupt pulse marks every capture except the first one after counting is enabled, because that first interval starts at an arbitrary point. A sticky overflow flag reports that the counter has wrapped. Any write strobe to the mode register clears that flag.

Top module: `pulse_capture`

## Requirements
- R1: After reset, `cap_val` is 0, `irq` is 0 and `ovf` is 0.
- R2: With `width_mode`=0, only one polarity measures: falling edges when `edge_sel`=0, rising edges when `edge_sel`=1. Each later capture equals the number of count ticks between two successive measuring edges.
- R3: With `width_mode`=1, every edge measures and `edge_sel` has no effect. A capture taken on a falling edge equals the high time in ticks. A capture taken on a rising edge equals the low time in ticks.
- R4: `clk_sel` sets the count tick as follows: 0 gives every clock, 1 gives every 16th clock, 2 gives every 64th clock, and 3 gives every 512th clock. Captured values are in these ticks.
- R5: `irq` pulses for one clock with each capture, except for the first capture after `run` goes from 0 to 1.
- R6: `cap_val` holds the last captured value. Between measuring edges it does not follow the running count.
- R7: `ovf` becomes 1 when the counter wraps from FFFFh to 0000h (65536 ticks with no measuring edge). It then stays at 1.
- R8: A one-clock `mode_wr` strobe clears `ovf`. The clear wins over a wrap in the same cycle.
- R9: While `run` is 0, the block does not count, capture or raise `irq`, and `cap_val` keeps its value.
- R10: Levels that last only two count ticks are still measured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Measured input, asynchronous to `clk` |
| clk_sel | input | 2 | Count-clock divider select |
| edge_sel | input | 1 | Period-mode polarity: 0 falling, 1 rising |
| width_mode | input | 1 | 1 selects width mode |
| run | input | 1 | Count start flag |
| mode_wr | input | 1 | Mode-register write strobe; clears `ovf` |
| cap_val | output | 16 | Captured interval |
| irq | output | 1 | One-clock interrupt request |
| ovf | output | 1 | Sticky counter-wrap flag |

## Verification
Square waves with unequal high and low times are applied under every divider setting.

- In period mode, the result is the sum of the high and low times. In width mode, the result after a final rising edge is the low time alone. Unequal times therefore show that the right polarity measured in each mode.
- Counting interrupt pulses over a known number of edges shows that the first capture was suppressed and that none of the later ones was.
- A case with two-tick levels tests the fastest input the block must follow.
- A long stretch with no edges drives the counter through its wrap, which exercises the overflow flag and its clear.

// File: rtl/pulse_capture.sv
module pulse_capture #(
  parameter int WIDTH = 16,
  parameter int DIV1  = 16,
  parameter int DIV2  = 64,
  parameter int DIV3  = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic [1:0]       clk_sel,
  input  logic             edge_sel,
  input  logic             width_mode,
  input  logic             run,
  input  logic             mode_wr,
  output logic [WIDTH-1:0] cap_val,
  output logic             irq,
  output logic             ovf
);
  localparam int PW = $clog2(DIV3 + 1);

  logic [1:0]       sync;
  logic             pin_prev;
  logic [PW-1:0]    presc;
  logic [PW-1:0]    div_m1;
  logic [WIDTH-1:0] cnt;
  logic             armed;
  logic             tick, edge_seen, rise, meas;

  always_comb begin
    case (clk_sel)
      2'd0:    div_m1 = '0;
      2'd1:    div_m1 = PW'(DIV1 - 1);
      2'd2:    div_m1 = PW'(DIV2 - 1);
      default: div_m1 = PW'(DIV3 - 1);
    endcase
  end

  assign tick      = run && (presc >= div_m1);
  assign edge_seen = sync[1] ^ pin_prev;
  assign rise      = sync[1] & ~pin_prev;
  assign meas      = tick && edge_seen && (width_mode || (rise == edge_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= '0;
      pin_prev <= 1'b0;
      presc    <= '0;
      cnt      <= '0;
      cap_val  <= '0;
      armed    <= 1'b0;
      irq      <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      sync <= {sync[0], pin_in};
      irq  <= meas && armed;
      if (mode_wr)
        ovf <= 1'b0;
      else if (tick && !meas && (&cnt))
        ovf <= 1'b1;
      if (!run) begin
        presc    <= '0;
        cnt      <= '0;
        armed    <= 1'b0;
        pin_prev <= sync[1];
      end else begin
        presc <= tick ? '0 : presc + 1'b1;
        if (tick) begin
          pin_prev <= sync[1];
          if (meas) begin
            cap_val <= cnt;
            cnt     <= WIDTH'(1);
            armed   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pulse_capture_chk.sv
module pulse_capture_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             mode_wr,
  input logic             meas,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] cap_val,
  input logic             irq,
  input logic             ovf
);
  p_no_irq_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq);

  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cap_val));

  p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !ovf);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !mode_wr) |=> ovf);

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    meas |=> (cnt == WIDTH'(1)));

  p_irq_needs_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !meas |=> !irq);
endmodule

bind pulse_capture pulse_capture_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode_wr(mode_wr), .meas(meas),
  .cnt(cnt), .cap_val(cap_val), .irq(irq), .ovf(ovf)
);

// File: tb/pulse_capture_tb.sv
module pulse_capture_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pin_in = 1;
  logic [1:0]  clk_sel = 0;
  logic        edge_sel = 0;
  logic        width_mode = 0;
  logic        run = 0;
  logic        mode_wr = 0;
  logic [15:0] cap_val;
  logic        irq;
  logic        ovf;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  logic [15:0] last_cap = 0;

  always #2 clk = ~clk;

  pulse_capture dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .clk_sel(clk_sel),
    .edge_sel(edge_sel), .width_mode(width_mode), .run(run),
    .mode_wr(mode_wr), .cap_val(cap_val), .irq(irq), .ovf(ovf)
  );

  always @(negedge clk) if (irq) begin
    irq_cnt  = irq_cnt + 1;
    last_cap = cap_val;
  end

  // {clk_sel, edge_sel, width_mode, high ticks, low ticks, expected capture}
  localparam int NV = 7;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 12'd5,   12'd3,   16'd8},
    {2'd0, 1'b1, 1'b0, 12'd2,   12'd2,   16'd4},
    {2'd1, 1'b0, 1'b0, 12'd3,   12'd6,   16'd9},
    {2'd2, 1'b1, 1'b1, 12'd4,   12'd7,   16'd7},
    {2'd3, 1'b0, 1'b1, 12'd3,   12'd2,   16'd2},
    {2'd0, 1'b1, 1'b1, 12'd6,   12'd2,   16'd2},
    {2'd0, 1'b0, 1'b0, 12'd300, 12'd200, 16'd500}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 16;
      2'd2: return 64;
      default: return 512;
    endcase
  endfunction

  initial begin
    fork
      begin
        cycles(190000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    join_none

    cycles(3);
    check("R1 cap", cap_val, 0);
    check("R1 irq", irq, 0);
    check("R1 ovf", ovf, 0);
    rst_n = 1;
    cycles(3);

    // R5: the first capture after start is silent
    irq_cnt = 0;
    run = 1;
    cycles(20);
    pin_in = 0;
    cycles(8);
    check("R5 first capture irq", irq_cnt, 0);
    check("R5 first capture taken", (cap_val != 0), 1);
    run = 0;
    pin_in = 1;
    cycles(5);

    for (int v = 0; v < NV; v++) begin
      int d, h, l, nirq;
      clk_sel    = VEC[v][43:42];
      edge_sel   = VEC[v][41];
      width_mode = VEC[v][40];
      h = int'(VEC[v][39:28]);
      l = int'(VEC[v][27:16]);
      d = div_of(clk_sel);
      nirq = width_mode ? 7 : 3;
      pin_in = 1;
      cycles(5);
      irq_cnt = 0;
      run = 1;
      cycles(3);
      for (int k = 0; k < 4; k++) begin
        pin_in = 0;
        cycles(l * d);
        pin_in = 1;
        cycles(h * d);
      end
      cycles(2 * d + 8);
      check(width_mode ? "R3 capture" : "R2 R4 R10 capture", last_cap, int'(VEC[v][15:0]));
      check("R5 irq count", irq_cnt, nirq);
      cycles(300);
      check("R6 cap holds", cap_val, int'(VEC[v][15:0]));
      run = 0;
      cycles(3);
    end

    // R9: stopped block ignores the input
    irq_cnt = 0;
    last_cap = cap_val;
    for (int k = 0; k < 5; k++) begin
      pin_in = ~pin_in;
      cycles(10);
    end
    check("R9 no irq", irq_cnt, 0);
    check("R9 cap kept", cap_val, int'(last_cap));

    // R7 / R8: overflow and clear
    clk_sel = 0;
    pin_in = 1;
    cycles(5);
    run = 1;
    cycles(65530);
    check("R7 no early ovf", ovf, 0);
    cycles(20);
    check("R7 ovf set", ovf, 1);
    cycles(50);
    check("R7 ovf sticky", ovf, 1);
    mode_wr = 1;
    cycles(1);
    mode_wr = 0;
    cycles(1);
    check("R8 ovf cleared", ovf, 0);
    run = 0;
    cycles(5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule